// File: doc/BRIEF.md
# Legacy BIOS ROM Address Decoder

This block takes 32-bit host memory addresses and decides whether each one is a firmware ROM access. Eight enable bits, held in one byte-wide configuration register, switch optional windows on or off. Six of these windows are 32 KB slices of the legacy area just below 1 MB. The other two are a 1 MB window and a 4 MB window near the top of the 4 GB space. Two 64 KB windows are always decoded, whatever the enables hold: the last 64 KB below 1 MB and the last 64 KB of the address space.

A route-select input picks the bus that serves the access. When it selects the narrow 24-bit bus, a hit in the legacy area is moved to the top of the 16 MB range, and a high hit keeps its low 24 bits. When it selects the wide firmware bus, a legacy-area hit is moved just below 4 GB, and a high hit passes through unchanged. Each request strobe produces, one clock later, a registered result: a hit flag, the bus chosen, the translated address, and a ROM chip-select for the narrow bus.

Top module: `bios_rom_decode`

## Requirements
- R1: After reset the enable register reads 00h and `rsp_valid`, `rsp_hit` and `rom_cs` are 0.
- R2: A cycle with `cfg_wr_en`=1 loads `cfg_wdata` into the enable register. `cfg_rdata` shows the new value from the next cycle on.
- R3: Enable bit k (k=0..5) decodes the 32 KB window from 000C_0000h+k*8000h to 000C_7FFFh+k*8000h. When bit k is 0, that window misses.
- R4: Enable bit 6 decodes FFB0_0000h–FFBF_FFFFh. Enable bit 7 decodes FFC0_0000h–FFFF_FFFFh.
- R5: 000F_0000h–000F_FFFFh and FFFF_0000h–FFFF_FFFFh always hit, for every enable value.
- R6: Any address outside every enabled or fixed window gives `rsp_hit`=0, `rsp_addr`=0 and `rom_cs`=0.
- R7: With `isa_route`=1, a hit below 1 MB gives `rsp_addr` = address + 00F0_0000h (FC_0000h–FF_FFFFh). A hit at or above 1 MB gives address[23:0], zero-extended to 32 bits.
- R8: With `isa_route`=0, a hit below 1 MB gives `rsp_addr` = address + FFF0_0000h (FFFC_0000h–FFFF_FFFFh). A hit at or above 1 MB gives the address unchanged.
- R9: `rsp_to_isa` repeats the route select of the request. `rom_cs` is 1 exactly when `rsp_hit`=1 and `rsp_to_isa`=1.
- R10: `rsp_valid` is 1 in the cycle after each cycle with `req_valid`=1, and 0 otherwise. The result uses the enable value held at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register contents |
| isa_route | input | 1 | 1 = narrow 24-bit bus, 0 = wide firmware bus |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Host memory address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Address decoded as a ROM access |
| rsp_to_isa | output | 1 | Route select of the request |
| rsp_addr | output | 32 | Translated address (0 on a miss) |
| rom_cs | output | 1 | ROM chip-select for a narrow-bus hit |

## Verification
The bench applies all 256 enable values. For each value it issues a fixed set of addresses placed on both sides of every window edge: each xxx7FFFh/xxx8000h boundary of the 32 KB slices, 000B_FFFFh against 000C_0000h, FFAF_FFFFh against FFB0_0000h, FFBF_FFFFh against FFC0_0000h, and FFFE_FFFFh against FFFF_0000h. It also issues far-away addresses that must always miss. This separates per-bit window selection from the fixed windows, and it exposes off-by-one slice indexing. The route select alternates from request to request, so both translations and the chip-select are compared against a behavioural range model on every clock. Back-to-back requests and idle gaps check the one-cycle result timing.

// File: rtl/bios_dec_pkg.sv
package bios_dec_pkg;
  localparam int ADDR_W   = 32;
  localparam int ISA_W    = 24;
  localparam int SEG_N    = 8;
  localparam int LOW_SEGS = 6;
  localparam int SLICE_LG = 15;              // 32 KB slices
  localparam int LOW_LG   = 18;              // 256 KB legacy ROM area
  localparam int MB_LG    = 20;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  hit;
    logic  to_isa;
    logic  cs;
    addr_t addr;
  } dec_res_t;

  // Address lies in the 000C_0000h..000F_FFFFh legacy area
  function automatic logic in_low_area(addr_t a);
    return a[ADDR_W-1:LOW_LG] == (ADDR_W-LOW_LG)'(3);
  endfunction

  // Slice number inside the legacy area (0..7)
  function automatic logic [2:0] low_slice(addr_t a);
    return a[LOW_LG-1:SLICE_LG];
  endfunction

  // Narrow-bus address: legacy hits move to the top of 16 MB
  function automatic addr_t xlate_narrow(addr_t a, logic low);
    addr_t r;
    r = '0;
    if (low) r[ISA_W-1:0] = {4'hF, a[MB_LG-1:0]};
    else     r[ISA_W-1:0] = a[ISA_W-1:0];
    return r;
  endfunction

  // Wide-bus address: legacy hits move just below 4 GB
  function automatic addr_t xlate_wide(addr_t a, logic low);
    addr_t r;
    if (low) r = {{(ADDR_W-MB_LG){1'b1}}, a[MB_LG-1:0]};
    else     r = a;
    return r;
  endfunction
endpackage

// File: rtl/seg_enable_reg.sv
module seg_enable_reg #(
  parameter int W = bios_dec_pkg::SEG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/window_match.sv
module window_match
  import bios_dec_pkg::*;
(
  input  addr_t            addr,
  input  logic [SEG_N-1:0] en,
  output logic [SEG_N-1:0] seg_hit,
  output logic             fixed_hit,
  output logic             low_area,
  output logic             any_hit
);
  logic [2:0] slice;

  assign low_area = in_low_area(addr);
  assign slice    = low_slice(addr);

  genvar gi;
  generate
    for (gi = 0; gi < LOW_SEGS; gi++) begin : g_low
      assign seg_hit[gi] = en[gi] && low_area && (slice == 3'(gi));
    end
  endgenerate

  // 1 MB window FFB0_0000h..FFBF_FFFFh
  assign seg_hit[6] = en[6] && (addr[ADDR_W-1:20] == 12'hFFB);
  // 4 MB window FFC0_0000h..FFFF_FFFFh
  assign seg_hit[7] = en[7] && (addr[ADDR_W-1:22] == 10'h3FF);

  assign fixed_hit = (addr[ADDR_W-1:16] == 16'h000F) ||
                     (addr[ADDR_W-1:16] == 16'hFFFF);

  assign any_hit = fixed_hit || (|seg_hit);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import bios_dec_pkg::*;
(
  input  addr_t addr,
  input  logic  low_area,
  input  logic  narrow,
  output addr_t xaddr
);
  addr_t narrow_a, wide_a;

  assign narrow_a = xlate_narrow(addr, low_area);
  assign wide_a   = xlate_wide(addr, low_area);
  assign xaddr    = narrow ? narrow_a : wide_a;
endmodule

// File: rtl/bios_rom_decode.sv
module bios_rom_decode
  import bios_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEG_N-1:0]  cfg_wdata,
  output logic [SEG_N-1:0]  cfg_rdata,
  input  logic              isa_route,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_to_isa,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rom_cs
);
  logic [SEG_N-1:0] en_q;
  logic [SEG_N-1:0] seg_hit_w;
  logic             fixed_hit_w, low_area_w, any_hit_w;
  addr_t            xaddr_w;
  dec_res_t         res_d, res_q;
  logic             vld_q;

  seg_enable_reg #(.W(SEG_N)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata), .q(en_q)
  );

  window_match u_match (
    .addr(req_addr), .en(en_q), .seg_hit(seg_hit_w),
    .fixed_hit(fixed_hit_w), .low_area(low_area_w), .any_hit(any_hit_w)
  );

  addr_xlate u_xlate (
    .addr(req_addr), .low_area(low_area_w), .narrow(isa_route), .xaddr(xaddr_w)
  );

  always_comb begin
    res_d        = '0;
    res_d.to_isa = isa_route;
    if (req_valid && any_hit_w) begin
      res_d.hit  = 1'b1;
      res_d.cs   = isa_route;
      res_d.addr = xaddr_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= req_valid;
      res_q <= res_d;
    end
  end

  assign cfg_rdata  = en_q;
  assign rsp_valid  = vld_q;
  assign rsp_hit    = res_q.hit;
  assign rsp_to_isa = res_q.to_isa;
  assign rsp_addr   = res_q.addr;
  assign rom_cs     = res_q.cs;

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit);

  // R5
  fixed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fixed_hit_w) |=> rsp_hit);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_addr == '0) && !rom_cs);

  // R9
  cs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs == (rsp_hit && rsp_to_isa));

  // R7
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_to_isa) |-> (rsp_addr[ADDR_W-1:ISA_W] == '0) &&
                               (rsp_addr[ISA_W-1:20] >= 4'hB));

  // R8
  wide_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !rsp_to_isa) |-> (rsp_addr[ADDR_W-1:24] == 8'hFF));

  // R3
  low_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_hit_w));
endmodule

// File: tb/sim_bios_rom_decode.sv
module sim_bios_rom_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        isa_route = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_to_isa, rom_cs;
  logic [31:0] rsp_addr;

  int checks = 0;
  int failures = 0;
  logic [7:0] model_en = 8'h00;

  typedef struct {logic hit; logic isa; logic [31:0] addr;} exp_t;
  exp_t pend[$];

  always #2 clk = ~clk;   // 250 MHz

  bios_rom_decode u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .isa_route(isa_route), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_to_isa(rsp_to_isa), .rsp_addr(rsp_addr), .rom_cs(rom_cs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural range model
  function automatic exp_t model(input logic [31:0] a, input logic [7:0] en, input logic isa);
    exp_t e;
    longint ua;
    int seg;
    ua = a;
    e.isa = isa; e.hit = 1'b0; e.addr = '0;
    if (ua >= 'hC0000 && ua <= 'hEFFFF) begin
      seg = int'((ua - 'hC0000) / 'h8000);
      e.hit = en[seg];
    end else if (ua >= 'hF0000 && ua <= 'hFFFFF) e.hit = 1'b1;
    else if (ua >= 'hFFFF0000) e.hit = 1'b1;
    else if (ua >= 'hFFC00000) e.hit = en[7];
    else if (ua >= 'hFFB00000 && ua <= 'hFFBFFFFF) e.hit = en[6];
    if (e.hit) begin
      if (ua < 'h100000) e.addr = isa ? 32'(ua + 'hF00000) : 32'(ua + 'hFFF00000);
      else               e.addr = isa ? 32'(ua & 'hFFFFFF) : a;
    end
    return e;
  endfunction

  // One clock: compare outputs from the last edge, then drive the next inputs
  task automatic tick(input logic v, input logic [31:0] a, input logic r,
                      input logic w, input logic [7:0] wd);
    exp_t e;
    @(negedge clk);
    chk("R2 cfg_rdata", {24'h0, cfg_rdata}, {24'h0, model_en});
    if (pend.size() > 0) begin
      e = pend.pop_front();
      chk("R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
      chk(e.hit ? "R3/R4/R5 rsp_hit" : "R6 rsp_hit", {31'h0, rsp_hit}, {31'h0, e.hit});
      chk("R9 rsp_to_isa", {31'h0, rsp_to_isa}, {31'h0, e.isa});
      chk("R9 rom_cs", {31'h0, rom_cs}, {31'h0, e.hit & e.isa});
      chk(e.isa ? "R7 rsp_addr" : "R8 rsp_addr", rsp_addr, e.addr);
    end else begin
      chk("R10 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    end
    req_valid = v; req_addr = a; isa_route = r;
    cfg_wr_en = w; cfg_wdata = wd;
    if (v) pend.push_back(model(a, model_en, r));
    if (w) model_en = wd;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [31:0] pts[$];
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_rdata", {24'h0, cfg_rdata}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 rsp_hit", {31'h0, rsp_hit}, 32'h0);
    chk("R1 rom_cs", {31'h0, rom_cs}, 32'h0);

    for (int k = 0; k < 6; k++) begin
      pts.push_back(32'hC0000 + k * 32'h8000);
      pts.push_back(32'hC7FFF + k * 32'h8000);
      pts.push_back(32'hC4321 + k * 32'h8000);
    end
    pts.push_back(32'h000BFFFF); pts.push_back(32'h000F0000);
    pts.push_back(32'h000FFFFF); pts.push_back(32'h00100000);
    pts.push_back(32'hFFAFFFFF); pts.push_back(32'hFFB00000);
    pts.push_back(32'hFFBFFFFF); pts.push_back(32'hFFC00000);
    pts.push_back(32'hFFFEFFFF); pts.push_back(32'hFFFF0000);
    pts.push_back(32'hFFFFFFFF); pts.push_back(32'h00000000);
    pts.push_back(32'h120C0000); pts.push_back(32'h7FFC0000);

    // Requests at reset value of the enables (fixed windows only)
    r = 1'b0;
    foreach (pts[i]) begin
      tick(1'b1, pts[i], r, 1'b0, 8'h00);
      r = ~r;
    end

    for (int en = 0; en < 256; en++) begin
      tick(1'b0, 32'h0, 1'b0, 1'b1, 8'(en));
      tick(1'b0, 32'h0, 1'b0, 1'b0, 8'h00);   // idle gap
      foreach (pts[i]) begin
        tick(1'b1, pts[i], r, 1'b0, 8'h00);
        r = ~r;
      end
      r = ~r;
    end
    tick(1'b0, 32'h0, 1'b0, 1'b0, 8'h00);
    tick(1'b0, 32'h0, 1'b0, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule